// File: doc/BRIEF.md
# Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A transmit engine and a receive engine run side by side. Each has its own holding register, so software can queue the next character while the current one is still on the wire, and can read a finished character while the next one arrives. Both engines use one frame setting: 7 or 8 data bits, no parity or even or odd parity, and 1 or 2 stop bits. A divider turns the system clock into a tick at sixteen times the bit rate. Both engines count their bit periods in that tick.

The serial lines can be routed to one of two pad pairs. A select input picks the pair that carries traffic. The transmit pad of the other pair stays at the idle level, and the receive pad of the other pair is not looked at. The select and the frame fields should only change while both engines are idle.

Status outputs report the following: the transmit holding register is empty, the transmitter has fully finished, a received character is waiting, and that character had a parity or framing error. A separate flag reports that a character was lost because the previous one had not been read.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, both transmit pads are high, tx_empty and tx_done are 1, and rx_full, rx_perr, rx_ferr and rx_ovr are 0. The selected transmit pad is high whenever no frame is being sent.
- R2: A transmitted frame is, in line order: one start bit at 0, then the data bits with bit 0 first (7 bits when len7=1, 8 bits otherwise), then the parity bit if enabled, then the stop bits at 1. Each bit lasts 16*(baud_div+1) clock cycles.
- R3: With par_en=1, the parity bit makes the count of ones over the data bits plus the parity bit even when par_odd=0, and odd when par_odd=1. With par_en=0, no parity bit is sent.
- R4: The transmitter holds the line at 1 for one stop bit when stop2=0 and for two stop bits when stop2=1. The frame length is therefore 1 + data bits + parity bit + stop bits, in bit periods.
- R5: A tx_wr pulse loads tx_wdata into the holding register, and tx_empty reads 0 on the next cycle. tx_empty returns to 1 when the engine takes the byte. A byte that is waiting when a frame ends starts at once, with no idle time on the line.
- R6: tx_done clears on tx_wr. It sets when the last stop bit ends while no byte is waiting.
- R7: The receiver starts on a 1-to-0 transition of the idle line. It samples each bit near the middle of its period. At the first stop bit it delivers the data on rx_rdata (bit 7 reads 0 in 7-bit mode) and sets rx_full. An rx_rd pulse clears rx_full.
- R8: A low level that is high again at the middle of the start bit is discarded, and no character is delivered.
- R9: rx_perr is 1 with a delivered character whose received parity bit does not match the configured even or odd parity. It is always 0 when parity is disabled.
- R10: rx_ferr is 1 with a delivered character whose first stop bit was sampled as 0. After such a frame, the receiver waits for the line to return high before it accepts a new start bit.
- R11: If a frame completes while rx_full is 1 and no rx_rd is present, that frame is discarded, rx_rdata keeps the unread character, and rx_ovr sets. rx_rd clears rx_ovr.
- R12: pad_sel=0 routes traffic through pad0_txd/pad0_rxd, and pad_sel=1 through pad1_txd/pad1_rxd. The unselected transmit pad stays at 1, and activity on the unselected receive pad has no effect.
- R13: The transmitter and receiver work at the same time. A frame sent on a transmit pad that is looped back to its receive pad is received intact while it is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Oversampling tick period minus one, in clock cycles |
| len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop2 | input | 1 | 1 selects two stop bits |
| pad_sel | input | 1 | Pad pair select |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Character to send |
| rx_rd | input | 1 | Read strobe, frees the receive holding register |
| rx_rdata | output | 8 | Last received character |
| tx_empty | output | 1 | Transmit holding register free |
| tx_done | output | 1 | Transmitter idle with nothing waiting |
| rx_full | output | 1 | Received character waiting |
| rx_perr | output | 1 | Parity error on the waiting character |
| rx_ferr | output | 1 | Framing error on the waiting character |
| rx_ovr | output | 1 | A character was lost to overrun |
| pad0_rxd | input | 1 | Receive pad, pair 0 |
| pad1_rxd | input | 1 | Receive pad, pair 1 |
| pad0_txd | output | 1 | Transmit pad, pair 0 |
| pad1_txd | output | 1 | Transmit pad, pair 1 |

## Verification
A transmit frame starts within one oversampling tick after a write reaches an idle engine. Each line bit then lasts exactly 16*(baud_div+1) cycles, so the bench finds the falling start edge and samples every later bit at its middle, where no edge is close. tx_done is due exactly one frame length after the start edge, and the bench accepts a margin of two cycles for its own edge detection. Receive results are due three cycles after the middle of the first stop bit: two synchronizer stages and the delivery register. The bench therefore reads the flags only after it has finished driving the whole stop period, plus a short settle time.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

  localparam int DATA_W    = 8;
  localparam int FRAME_MAX = 12;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  // total line bits of one frame, start bit included
  function automatic logic [3:0] frame_bits(frame_cfg_t c);
    logic [3:0] n;
    n = 4'd1 + (c.len7 ? 4'd7 : 4'd8) + {3'b000, c.par_en} + (c.stop2 ? 4'd2 : 4'd1);
    return n;
  endfunction

  // parity bit for the configured data length and sense
  function automatic logic par_bit(logic [DATA_W-1:0] d, frame_cfg_t c);
    logic [DATA_W-1:0] m;
    m = d;
    if (c.len7) m[DATA_W-1] = 1'b0;
    return (^m) ^ c.par_odd;
  endfunction

  // line image, LSB goes out first, unused tail bits are idle/stop level
  function automatic logic [FRAME_MAX-1:0] build_frame(logic [DATA_W-1:0] d, frame_cfg_t c);
    logic [FRAME_MAX-1:0] f;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (!(c.len7 && i == DATA_W - 1)) f[i+1] = d[i];
    end
    if (c.par_en) begin
      if (c.len7) f[DATA_W]   = par_bit(d, c);
      else        f[DATA_W+1] = par_bit(d, c);
    end
    return f;
  endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_xcvr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              txd,
  output logic              hold_empty,
  output logic              done,
  output logic              busy,
  output logic              load,
  output logic              frame_end
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

  logic [DATA_W-1:0]    hold_q;
  logic                 hold_v_q;
  logic [FRAME_MAX-1:0] sh_q;
  logic [3:0]           left_q;
  logic [PW-1:0]        ph_q;
  logic                 busy_q;
  logic                 done_q;
  logic                 last_bit;

  assign last_bit   = busy_q && tick && (ph_q == PH_LAST) && (left_q == 4'd1);
  assign load       = tick && hold_v_q && (!busy_q || last_bit);
  assign frame_end  = last_bit && !load;
  assign txd        = busy_q ? sh_q[0] : 1'b1;
  assign hold_empty = !hold_v_q;
  assign busy       = busy_q;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else begin
      if (load) hold_v_q <= 1'b0;
      if (wr) begin
        hold_q   <= wdata;
        hold_v_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      ph_q   <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sh_q   <= build_frame(hold_q, cfg);
      left_q <= frame_bits(cfg);
      ph_q   <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tick) begin
      if (ph_q == PH_LAST) begin
        ph_q   <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == 4'd1) busy_q <= 1'b0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_q <= 1'b1;
    else if (wr)        done_q <= 1'b0;
    else if (frame_end) done_q <= 1'b1;
  end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_xcvr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  input  logic              rxd,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              perr,
  output logic              ferr,
  output logic              ovr,
  output logic              frame_done,
  output logic              start_reject
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_MID  = PW'(OVS / 2 - 1);

  rx_state_t         st_q;
  logic [PW-1:0]     ph_q;
  logic [2:0]        idx_q;
  logic [DATA_W-1:0] shd_q;
  logic              pgot_q;
  logic              armed_q;
  logic              samp;
  logic [2:0]        last_idx;

  logic [DATA_W-1:0] rbr_q;
  logic              full_q, perr_q, ferr_q, ovr_q;

  assign samp         = tick && (ph_q == PH_MID) && (st_q != RX_IDLE);
  assign last_idx     = cfg.len7 ? 3'd6 : 3'd7;
  assign frame_done   = samp && (st_q == RX_STOP);
  assign start_reject = samp && (st_q == RX_START) && rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      shd_q   <= '0;
      pgot_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (tick && st_q != RX_IDLE) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      case (st_q)
        RX_IDLE: begin
          if (rxd) armed_q <= 1'b1;
          if (tick && !rxd && armed_q) begin
            st_q  <= RX_START;
            ph_q  <= '0;
            idx_q <= '0;
            shd_q <= '0;
          end
        end
        RX_START: if (samp) st_q <= rxd ? RX_IDLE : RX_DATA;
        RX_DATA: if (samp) begin
          shd_q[idx_q] <= rxd;
          idx_q        <= idx_q + 1'b1;
          if (idx_q == last_idx) st_q <= cfg.par_en ? RX_PAR : RX_STOP;
        end
        RX_PAR: if (samp) begin
          pgot_q <= rxd;
          st_q   <= RX_STOP;
        end
        RX_STOP: if (samp) begin
          st_q    <= RX_IDLE;
          armed_q <= 1'b0;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q  <= '0;
      full_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rd) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (frame_done) begin
        if (full_q && !rd) begin
          ovr_q <= 1'b1;
        end else begin
          rbr_q  <= shd_q;
          perr_q <= cfg.par_en && (par_bit(shd_q, cfg) != pgot_q);
          ferr_q <= !rxd;
          full_q <= 1'b1;
        end
      end
    end
  end

  assign rdata = rbr_q;
  assign full  = full_q;
  assign perr  = perr_q;
  assign ferr  = ferr_q;
  assign ovr   = ovr_q;
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int OVS    = 16,   // power of two
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             len7,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             stop2,
  input  logic             pad_sel,
  input  logic             tx_wr,
  input  logic [7:0]       tx_wdata,
  input  logic             rx_rd,
  output logic [7:0]       rx_rdata,
  output logic             tx_empty,
  output logic             tx_done,
  output logic             rx_full,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_ovr,
  input  logic             pad0_rxd,
  input  logic             pad1_rxd,
  output logic             pad0_txd,
  output logic             pad1_txd
);
  frame_cfg_t cfg;
  logic tick_w;
  logic txd_w, tx_busy_w, tx_load_w, tx_end_w;
  logic rx_pin_w, rxd_s;
  logic rx_done_w, rx_reject_w;
  logic [SYNC_N-1:0] sync_q;

  assign cfg = '{len7: len7, par_en: par_en, par_odd: par_odd, stop2: stop2};

  uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick_w)
  );

  // pad routing: the unselected transmit pad idles at mark
  assign pad0_txd = pad_sel ? 1'b1  : txd_w;
  assign pad1_txd = pad_sel ? txd_w : 1'b1;
  assign rx_pin_w = pad_sel ? pad1_rxd : pad0_rxd;

  generate
    if (SYNC_N > 1) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_N-2:0], rx_pin_w};
      end
    end else begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rx_pin_w;
      end
    end
  endgenerate
  assign rxd_s = sync_q[SYNC_N-1];

  uart_tx_engine #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .cfg(cfg),
    .wr(tx_wr), .wdata(tx_wdata), .txd(txd_w),
    .hold_empty(tx_empty), .done(tx_done), .busy(tx_busy_w),
    .load(tx_load_w), .frame_end(tx_end_w)
  );

  uart_rx_engine #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .cfg(cfg),
    .rxd(rxd_s), .rd(rx_rd), .rdata(rx_rdata), .full(rx_full),
    .perr(rx_perr), .ferr(rx_ferr), .ovr(rx_ovr),
    .frame_done(rx_done_w), .start_reject(rx_reject_w)
  );
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_load,
  input logic tx_busy,
  input logic txd,
  input logic tx_wr,
  input logic tx_empty,
  input logic tx_done,
  input logic rx_done,
  input logic rx_reject,
  input logic rx_full,
  input logic rx_ovr,
  input logic pad0_txd,
  input logic pad1_txd
);
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (pad0_txd && pad1_txd));

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !txd);

  a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_empty);

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !tx_busy);

  a_r7_full_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_full);

  a_r8_reject_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_reject && !rx_full) |=> !rx_full);

  a_r11_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_full));
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_load(tx_load_w), .tx_busy(tx_busy_w),
  .txd(txd_w), .tx_wr(tx_wr), .tx_empty(tx_empty), .tx_done(tx_done),
  .rx_done(rx_done_w), .rx_reject(rx_reject_w), .rx_full(rx_full),
  .rx_ovr(rx_ovr), .pad0_txd(pad0_txd), .pad1_txd(pad1_txd)
);

// File: tb/uart_xcvr_tb.sv
module uart_xcvr_tb;
  localparam int DIV = 1;
  localparam int BIT = 16 * (DIV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l7 = 0, pe = 0, po = 0, s2 = 0, psel = 0;
  logic tx_wr = 0, rx_rd = 0;
  logic [7:0] tx_wdata = '0;
  logic [7:0] rx_rdata;
  logic tx_empty, tx_done, rx_full, rx_perr, rx_ferr, rx_ovr;
  logic pad0_txd, pad1_txd;
  logic drv0 = 1'b1, drv1 = 1'b1, loop = 1'b0;
  logic pad0_rxd, pad1_rxd;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign pad0_rxd = loop ? pad0_txd : drv0;
  assign pad1_rxd = drv1;

  uart_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(16'(DIV)), .len7(l7), .par_en(pe),
    .par_odd(po), .stop2(s2), .pad_sel(psel), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .tx_empty(tx_empty), .tx_done(tx_done),
    .rx_full(rx_full), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr),
    .pad0_rxd(pad0_rxd), .pad1_rxd(pad1_rxd), .pad0_txd(pad0_txd), .pad1_txd(pad1_txd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_par(logic [7:0] d, bit short, bit odd);
    int ones = 0;
    for (int i = 0; i < (short ? 7 : 8); i++) ones += int'(d[i]);
    return logic'(ones % 2) ^ odd;
  endfunction

  function automatic int exp_len();
    return 1 + (l7 ? 7 : 8) + int'(pe) + (s2 ? 2 : 1);
  endfunction

  function automatic logic sel_tx();
    return psel ? pad1_txd : pad0_txd;
  endfunction

  function automatic logic other_tx();
    return psel ? pad0_txd : pad1_txd;
  endfunction

  task automatic set_cfg(input bit a, input bit b, input bit c, input bit d);
    @(negedge clk);
    l7 = a; pe = b; po = c; s2 = d;
  endtask

  task automatic write_tx(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic put(input bit pad, input logic v);
    if (pad) drv1 = v; else drv0 = v;
    repeat (BIT) @(negedge clk);
  endtask

  // captures one frame from the selected pad, samples at bit middles
  task automatic capture(input bit started, output logic [7:0] d, output logic p,
                         output logic [1:0] stp, output int t0, output int oth_low);
    oth_low = 0;
    if (!started) while (sel_tx()) @(negedge clk);
    t0 = cyc;
    repeat (BIT / 2) @(negedge clk);
    chk(sel_tx() == 1'b0, "R2 start bit", int'(sel_tx()), 0);
    d = '0; p = 1'b0; stp = 2'b11;
    for (int i = 0; i < (l7 ? 7 : 8); i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = sel_tx();
      if (!other_tx()) oth_low++;
    end
    if (pe) begin repeat (BIT) @(negedge clk); p = sel_tx(); end
    repeat (BIT) @(negedge clk); stp[0] = sel_tx();
    if (s2) begin repeat (BIT) @(negedge clk); stp[1] = sel_tx(); end
  endtask

  task automatic drive_rx(input bit pad, input logic [7:0] d, input bit flip_par, input bit stop_lo);
    put(pad, 1'b0);
    for (int i = 0; i < (l7 ? 7 : 8); i++) put(pad, d[i]);
    if (pe) put(pad, exp_par(d, l7, po) ^ flip_par);
    put(pad, !stop_lo);
    if (s2) put(pad, 1'b1);
    if (stop_lo) put(pad, 1'b1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_empty && tx_done, "R1 tx flags", {tx_empty, tx_done}, 3);
    chk(!rx_full && !rx_perr && !rx_ferr && !rx_ovr, "R1 rx flags",
        {rx_full, rx_perr, rx_ferr, rx_ovr}, 0);
    chk(pad0_txd && pad1_txd, "R1 pads idle", {pad0_txd, pad1_txd}, 3);
  endtask

  task automatic t_tx(input logic [7:0] d, input bit a, input bit b, input bit c, input bit e);
    logic [7:0] got; logic p; logic [1:0] stp; int t0, ol, dt;
    set_cfg(a, b, c, e);
    write_tx(d);
    chk(tx_done == 1'b0, "R6 done cleared by write", int'(tx_done), 0);
    capture(1'b0, got, p, stp, t0, ol);
    chk(got == (l7 ? {1'b0, d[6:0]} : d), "R2 data LSB first", got, l7 ? {1'b0, d[6:0]} : d);
    if (pe) chk(p == exp_par(d, l7, po), "R3 parity bit", p, exp_par(d, l7, po));
    chk(stp == 2'b11, "R4 stop bits high", stp, 3);
    while (!tx_done && cyc - t0 < 4000) @(negedge clk);
    dt = cyc - t0;
    chk(dt >= exp_len() * BIT - 2 && dt <= exp_len() * BIT + 2, "R4 R6 frame length", dt, exp_len() * BIT);
  endtask

  task automatic t_b2b();
    logic [7:0] g; logic p; logic [1:0] stp; int t0, ol, t1;
    set_cfg(0, 0, 0, 0);
    write_tx(8'hA5);
    while (!tx_empty) @(negedge clk);
    write_tx(8'h3C);
    chk(tx_empty == 1'b0, "R5 holding reg filled", int'(tx_empty), 0);
    capture(1'b0, g, p, stp, t0, ol);
    chk(g == 8'hA5, "R5 first byte", g, 8'hA5);
    chk(tx_done == 1'b0, "R6 done held while byte waits", int'(tx_done), 0);
    t1 = cyc;
    while (sel_tx() && cyc - t1 < 4000) @(negedge clk);
    chk(cyc - t1 <= BIT / 2 + 2, "R5 no gap between frames", cyc - t1, BIT / 2);
    capture(1'b1, g, p, stp, t0, ol);
    chk(g == 8'h3C, "R5 second byte", g, 8'h3C);
    while (!tx_done) @(negedge clk);
  endtask

  task automatic t_rx(input logic [7:0] d, input bit a, input bit b, input bit c, input bit e);
    logic [7:0] ex;
    set_cfg(a, b, c, e);
    ex = a ? {1'b0, d[6:0]} : d;
    drive_rx(1'b0, d, 1'b0, 1'b0);
    chk(rx_full == 1'b1, "R7 full after frame", int'(rx_full), 1);
    chk(rx_rdata == ex, "R7 received data", rx_rdata, ex);
    chk(!rx_perr && !rx_ferr, "R9 R10 clean frame flags", {rx_perr, rx_ferr}, 0);
    read_rx();
    chk(rx_full == 1'b0, "R7 read frees buffer", int'(rx_full), 0);
  endtask

  task automatic t_rx_err();
    set_cfg(0, 1, 1, 0);
    drive_rx(1'b0, 8'h5A, 1'b1, 1'b0);
    chk(rx_perr == 1'b1, "R9 parity error", int'(rx_perr), 1);
    read_rx();
    set_cfg(0, 0, 0, 0);
    drive_rx(1'b0, 8'h81, 1'b0, 1'b1);
    chk(rx_ferr == 1'b1 && rx_rdata == 8'h81, "R10 framing error", {rx_ferr, rx_rdata}, 9'h181);
    read_rx();
    repeat (2 * BIT) @(negedge clk);
    chk(rx_full == 1'b0, "R10 no spurious frame after bad stop", int'(rx_full), 0);
  endtask

  task automatic t_ovr();
    set_cfg(0, 0, 0, 0);
    drive_rx(1'b0, 8'h11, 1'b0, 1'b0);
    drive_rx(1'b0, 8'h22, 1'b0, 1'b0);
    chk(rx_ovr == 1'b1, "R11 overrun flag", int'(rx_ovr), 1);
    chk(rx_rdata == 8'h11, "R11 unread byte kept", rx_rdata, 8'h11);
    read_rx();
    chk(!rx_ovr && !rx_full, "R11 read clears", {rx_ovr, rx_full}, 0);
  endtask

  task automatic t_reject();
    set_cfg(0, 0, 0, 0);
    @(negedge clk); drv0 = 1'b0;
    repeat (4 * (DIV + 1)) @(negedge clk);
    drv0 = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    chk(rx_full == 1'b0, "R8 short low discarded", int'(rx_full), 0);
    t_rx(8'hC3, 0, 0, 0, 0);
  endtask

  task automatic t_pad();
    logic [7:0] g; logic p; logic [1:0] stp; int t0, ol;
    set_cfg(0, 0, 0, 0);
    psel = 1'b1; drv0 = 1'b0;
    write_tx(8'h96);
    capture(1'b0, g, p, stp, t0, ol);
    chk(g == 8'h96, "R12 frame on pad1", g, 8'h96);
    chk(ol == 0, "R12 pad0 tx held high", ol, 0);
    while (!tx_done) @(negedge clk);
    drive_rx(1'b1, 8'h4B, 1'b0, 1'b0);
    chk(rx_full && rx_rdata == 8'h4B, "R12 rx on pad1 with pad0 low", rx_rdata, 8'h4B);
    read_rx();
    drv0 = 1'b1;
    repeat (4) @(negedge clk);
    psel = 1'b0;
    repeat (BIT) @(negedge clk);
    chk(rx_full == 1'b0, "R12 unselected pad ignored", int'(rx_full), 0);
  endtask

  task automatic t_duplex();
    set_cfg(0, 1, 0, 1);
    loop = 1'b1;
    write_tx(8'hE7);
    while (!tx_done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rx_full && rx_rdata == 8'hE7 && !rx_perr, "R13 loopback byte", rx_rdata, 8'hE7);
    read_rx();
    loop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx(8'hB4, 0, 0, 0, 0);
    t_tx(8'h6D, 1, 1, 0, 1);
    t_tx(8'h6D, 0, 1, 1, 0);
    t_tx(8'hF0, 1, 0, 0, 1);
    t_b2b();
    t_rx(8'h5C, 0, 0, 0, 0);
    t_rx(8'hFF, 1, 1, 1, 1);
    t_rx(8'h37, 0, 1, 0, 0);
    t_rx_err();
    t_ovr();
    t_reject();
    t_pad();
    t_duplex();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule